// File: doc/BRIEF.md
# Triple-DES Block Cipher Engine with CBC Chaining

The engine encrypts or decrypts 64-bit blocks with single DES or triple DES, in electronic-codebook or cipher-block-chaining mode. A message starts with a one-cycle `msg_start_i` pulse while the engine is idle. The pulse captures up to three 64-bit keys (bit 0 of every key byte is a parity bit and is dropped), the 64-bit initial chaining value and the four mode controls. Blocks then enter on a valid/ready stream and leave on a second valid/ready stream.

One Feistel round is computed per clock. Round subkeys are derived on the fly: the key halves rotate left when a pass encrypts and right when a pass decrypts. Triple DES chains three passes back to back with no idle cycle between them. With `two_key_i` set, the first key also serves as the third key. In CBC mode one chaining register serves both directions. Encryption XORs the plaintext into the register value before the cipher and stores the ciphertext as the next chaining value. Decryption XORs the register value into the cipher output and stores the received ciphertext.

Top module: `tdes_cbc_engine`

## Requirements
- R1: With triple_i=0, cbc_i=0 and decrypt_i=0, a block is encrypted with standard DES under key1_i; key 133457799BBCDFF1 maps block 0123456789ABCDEF to 85E813540F0AB405.
- R2: With decrypt_i=1 in single-DES mode, the block is decrypted under key1_i, so a ciphertext produced under R1 returns the original plaintext.
- R3: With triple_i=1 and two_key_i=0, encryption is E(key3,D(key2,E(key1,x))) and decryption is D(key1,E(key2,D(key3,y))); with all three keys equal the result matches single DES.
- R4: With triple_i=1 and two_key_i=1, key1_i is used as the third key and key3_i has no effect on the output.
- R5: With cbc_i=1 and decrypt_i=0, each output is the cipher of (input XOR chaining value), and that output becomes the next chaining value.
- R6: With cbc_i=1 and decrypt_i=1, each output is (cipher output XOR chaining value), and the received input block becomes the next chaining value.
- R7: Bit 0 of each key byte is ignored: flipping those bits in any key leaves every output unchanged.
- R8: out_valid_o rises exactly 16 clock edges after the accepting edge in single-DES mode and 48 edges after it in triple-DES mode.
- R9: in_ready_o is low from the accepting edge until the result has been taken, and out_data_o holds steady while out_valid_o=1 and out_ready_i=0.
- R10: After reset, in_ready_o=1 and out_valid_o=0.
- R11: A msg_start_i pulse while idle reloads the chaining value from iv_i and latches keys and mode, so the same plaintext after the same IV gives the same first ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_start_i | input | 1 | Latch keys, mode and IV (honoured only while idle) |
| cbc_i | input | 1 | 1 = CBC, 0 = ECB |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| triple_i | input | 1 | 1 = triple DES, 0 = single DES |
| two_key_i | input | 1 | 1 = third key equals first key |
| key1_i | input | 64 | First key with parity bits |
| key2_i | input | 64 | Second key with parity bits |
| key3_i | input | 64 | Third key with parity bits |
| iv_i | input | 64 | Initial chaining value |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Engine can accept a block |
| in_data_i | input | 64 | Input block |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes result |
| out_data_o | output | 64 | Result block |

## Verification
The assertions assume that `msg_start_i` arrives only while the engine is idle. They also assume that a consumer that has seen `out_valid_o` keeps sampling until it raises `out_ready_i`. The stimulus pulses `msg_start_i` only between blocks, after the previous result has been taken and before the next `in_valid_i`. It offers one block at a time and drops `in_valid_i` after the accepting edge. It stalls `out_ready_i` for several cycles before releasing each result, so the hold property is exercised without breaking those assumptions.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  localparam int unsigned BLK_W  = 64;
  localparam int unsigned HALF_W = BLK_W / 2;
  localparam int unsigned CD_W   = 56;
  localparam int unsigned SK_W   = 48;
  localparam int unsigned ROUNDS = 16;
  localparam int unsigned RND_W  = $clog2(ROUNDS);
  localparam int unsigned PASS_W = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eng_state_e;

  // bit r set: key halves move by two positions before round r
  localparam logic [15:0] SHIFT_TWO = 16'h7EFC;

  localparam int PC1_T [56] = '{
    57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
    63,55,47,39,31,23,15, 7,62,54,46,38,30,22,14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};

  localparam int PC2_T [48] = '{
    14,17,11,24, 1, 5, 3,28,15, 6,21,10,23,19,12, 4,26, 8,16, 7,27,20,13, 2,
    41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

  localparam int P_T [32] = '{
    16, 7,20,21,29,12,28,17, 1,15,23,26, 5,18,31,10,
     2, 8,24,14,32,27, 3, 9,19,13,30, 6,22,11, 4,25};

  // each box: 64 nibbles, row-major, entry 0 in the top nibble
  localparam logic [255:0] SBOX_T [8] = '{
    256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D,
    256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9,
    256'hA09E63F51DC7B428D709346A285ECBF1D6498F30B12C5AE71AD069874FE3B52C,
    256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E,
    256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453,
    256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D,
    256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C,
    256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B};

  function automatic int ip_src(input int i);
    int r, c;
    r = i / 8;
    c = i % 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
  endfunction

  function automatic logic [63:0] init_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[63-i] = x[64-ip_src(i)];
    return y;
  endfunction

  function automatic logic [63:0] final_perm(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[64-ip_src(i)] = x[63-i];
    return y;
  endfunction

  function automatic logic [47:0] expand(input logic [31:0] r);
    logic [47:0] y;
    for (int g = 0; g < 8; g++)
      for (int k = 0; k < 6; k++)
        y[47-(6*g+k)] = r[32-(((4*g+k+31) % 32)+1)];
    return y;
  endfunction

  function automatic logic [3:0] sbox_get(input int n, input logic [5:0] b);
    int idx;
    idx = {26'd0, b[5], b[0], b[4:1]};
    return SBOX_T[n][255-4*idx -: 4];
  endfunction

  function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] t;
    logic [31:0] s, y;
    t = expand(r) ^ k;
    for (int n = 0; n < 8; n++) s[31-4*n -: 4] = sbox_get(n, t[47-6*n -: 6]);
    for (int i = 0; i < 32; i++) y[31-i] = s[32-P_T[i]];
    return y;
  endfunction

  function automatic logic [55:0] pc1(input logic [63:0] k);
    logic [55:0] y;
    for (int i = 0; i < 56; i++) y[55-i] = k[64-PC1_T[i]];
    return y;
  endfunction

  function automatic logic [47:0] pc2(input logic [55:0] cd);
    logic [47:0] y;
    for (int i = 0; i < 48; i++) y[47-i] = cd[56-PC2_T[i]];
    return y;
  endfunction

  function automatic logic [27:0] rot28(input logic [27:0] x, input logic left, input logic two);
    if (left) return two ? {x[25:0], x[27:26]} : {x[26:0], x[27]};
    else      return two ? {x[1:0], x[27:2]}   : {x[0], x[27:1]};
  endfunction

endpackage

// File: rtl/tdes_key_sched.sv
module tdes_key_sched
  import tdes_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BLK_W-1:0]   key_i,
  input  logic               dec_i,
  input  logic               step_i,
  input  logic [RND_W-1:0]   rnd_i,
  output logic [SK_W-1:0]    subkey_o
);

  logic [CD_W-1:0]  cd_q;
  logic             dec_q;
  logic [CD_W-1:0]  base;
  logic [RND_W-1:0] sh_idx;
  logic             two;

  assign base   = pc1(key_i);
  // encrypt: shift of the next round; decrypt: undo shift of the mirrored round
  assign sh_idx = dec_q ? (RND_W'(ROUNDS - 1) - rnd_i) : (rnd_i + RND_W'(1));
  assign two    = SHIFT_TWO[sh_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_q  <= '0;
      dec_q <= 1'b0;
    end else if (load_i) begin
      dec_q <= dec_i;
      cd_q  <= dec_i ? base : {rot28(base[55:28], 1'b1, 1'b0), rot28(base[27:0], 1'b1, 1'b0)};
    end else if (step_i) begin
      cd_q  <= {rot28(cd_q[55:28], !dec_q, two), rot28(cd_q[27:0], !dec_q, two)};
    end
  end

  assign subkey_o = pc2(cd_q);

  assert_load_step_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));

endmodule

// File: rtl/tdes_round.sv
module tdes_round
  import tdes_pkg::*;
(
  input  logic [HALF_W-1:0] l_i,
  input  logic [HALF_W-1:0] r_i,
  input  logic [SK_W-1:0]   subkey_i,
  input  logic              last_i,
  output logic [HALF_W-1:0] l_o,
  output logic [HALF_W-1:0] r_o
);

  logic [HALF_W-1:0] mixed;

  assign mixed = l_i ^ feistel(r_i, subkey_i);

  // last round skips the swap so the halves are already in output order
  always_comb begin
    if (last_i) begin
      l_o = mixed;
      r_o = r_i;
    end else begin
      l_o = r_i;
      r_o = mixed;
    end
  end

endmodule

// File: rtl/tdes_cbc_chain.sv
module tdes_cbc_chain
  import tdes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iv_load_i,
  input  logic [BLK_W-1:0] iv_i,
  input  logic             cbc_i,
  input  logic             dec_i,
  input  logic             accept_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             finish_i,
  input  logic [BLK_W-1:0] core_i,
  output logic [BLK_W-1:0] pre_o,
  output logic [BLK_W-1:0] post_o
);

  logic [BLK_W-1:0] chain_q, hold_q;

  assign pre_o  = (cbc_i && !dec_i) ? (blk_i ^ chain_q)  : blk_i;
  assign post_o = (cbc_i &&  dec_i) ? (core_i ^ chain_q) : core_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      hold_q  <= '0;
    end else begin
      if (iv_load_i) chain_q <= iv_i;
      else if (finish_i && cbc_i) chain_q <= dec_i ? hold_q : core_i;
      if (accept_i) hold_q <= blk_i;
    end
  end

  assert_iv_no_overlap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iv_load_i |-> !(accept_i || finish_i));

endmodule

// File: rtl/tdes_cbc_engine.sv
module tdes_cbc_engine
  import tdes_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        msg_start_i,
  input  logic        cbc_i,
  input  logic        decrypt_i,
  input  logic        triple_i,
  input  logic        two_key_i,
  input  logic [63:0] key1_i,
  input  logic [63:0] key2_i,
  input  logic [63:0] key3_i,
  input  logic [63:0] iv_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [63:0] in_data_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [63:0] out_data_o
);

  eng_state_e        state_q;
  logic [RND_W-1:0]  rnd_q;
  logic [PASS_W-1:0] pass_q;
  logic [BLK_W-1:0]  lr_q, out_q;
  logic [BLK_W-1:0]  k1_q, k2_q, k3_q;
  logic              cbc_q, dec_q, tri_q, two_q;

  logic              idle, accept, last_rnd, last_pass, finish, next_pass, ks_load, ks_step;
  logic [PASS_W-1:0] pass_sel, pass_end;
  logic [BLK_W-1:0]  ks_key, pre_blk, post_blk, core_blk;
  logic              ks_dec;
  logic [SK_W-1:0]   subkey;
  logic [HALF_W-1:0] l_nx, r_nx;

  assign idle       = (state_q == ST_IDLE);
  assign in_ready_o = idle && !msg_start_i;
  assign accept     = in_valid_i && in_ready_o;
  assign pass_end   = tri_q ? PASS_W'(2) : PASS_W'(0);
  assign last_rnd   = (rnd_q == RND_W'(ROUNDS - 1));
  assign last_pass  = (pass_q == pass_end);
  assign finish     = (state_q == ST_RUN) && last_rnd && last_pass;
  assign next_pass  = (state_q == ST_RUN) && last_rnd && !last_pass;
  assign ks_load    = accept || next_pass;
  assign ks_step    = (state_q == ST_RUN) && !last_rnd;
  assign pass_sel   = accept ? '0 : pass_q + PASS_W'(1);

  // key order and direction per pass; decryption walks the keys backwards
  always_comb begin
    logic [BLK_W-1:0] k3_eff;
    k3_eff = two_q ? k1_q : k3_q;
    ks_dec = dec_q ^ (pass_sel == PASS_W'(1));
    unique case (pass_sel)
      PASS_W'(0): ks_key = (tri_q && dec_q) ? k3_eff : k1_q;
      PASS_W'(1): ks_key = k2_q;
      default:    ks_key = dec_q ? k1_q : k3_eff;
    endcase
  end

  tdes_key_sched u_ks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ks_load),
    .key_i   (ks_key),
    .dec_i   (ks_dec),
    .step_i  (ks_step),
    .rnd_i   (rnd_q),
    .subkey_o(subkey)
  );

  tdes_round u_round (
    .l_i     (lr_q[63:32]),
    .r_i     (lr_q[31:0]),
    .subkey_i(subkey),
    .last_i  (last_rnd),
    .l_o     (l_nx),
    .r_o     (r_nx)
  );

  assign core_blk = final_perm({l_nx, r_nx});

  tdes_cbc_chain u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .iv_load_i(msg_start_i && idle),
    .iv_i     (iv_i),
    .cbc_i    (cbc_q),
    .dec_i    (dec_q),
    .accept_i (accept),
    .blk_i    (in_data_i),
    .finish_i (finish),
    .core_i   (core_blk),
    .pre_o    (pre_blk),
    .post_o   (post_blk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      pass_q  <= '0;
      lr_q    <= '0;
      out_q   <= '0;
      k1_q    <= '0;
      k2_q    <= '0;
      k3_q    <= '0;
      cbc_q   <= 1'b0;
      dec_q   <= 1'b0;
      tri_q   <= 1'b0;
      two_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (msg_start_i) begin
            k1_q  <= key1_i;
            k2_q  <= key2_i;
            k3_q  <= key3_i;
            cbc_q <= cbc_i;
            dec_q <= decrypt_i;
            tri_q <= triple_i;
            two_q <= two_key_i;
          end else if (accept) begin
            lr_q    <= init_perm(pre_blk);
            rnd_q   <= '0;
            pass_q  <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          lr_q  <= {l_nx, r_nx};
          rnd_q <= rnd_q + RND_W'(1);
          if (next_pass) pass_q <= pass_q + PASS_W'(1);
          if (finish) begin
            out_q   <= post_blk;
            state_q <= ST_DONE;
          end
        end
        default: begin
          if (out_ready_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign out_valid_o = (state_q == ST_DONE);
  assign out_data_o  = out_q;

  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_pass_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (pass_q <= pass_end));

  assert_done_after_final_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ($past(rnd_q) == RND_W'(ROUNDS - 1) && $past(pass_q) == pass_end));

  assert_no_valid_while_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && in_ready_o));

endmodule

// File: tb/tdes_cbc_engine_tb_top.sv
module tdes_cbc_engine_tb_top;
  import tdes_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_start = 1'b0, cbc = 1'b0, decrypt = 1'b0, triple = 1'b0, two_key = 1'b0;
  logic [63:0] key1 = '0, key2 = '0, key3 = '0, iv = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [63:0] m_k1, m_k2, m_k3, m_chain;
  bit          m_cbc, m_dec, m_tri, m_two;

  always #5 clk = ~clk;

  tdes_cbc_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .msg_start_i(msg_start), .cbc_i(cbc), .decrypt_i(decrypt),
    .triple_i(triple), .two_key_i(two_key), .key1_i(key1), .key2_i(key2), .key3_i(key3),
    .iv_i(iv), .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: full subkey table up front, left rotations only
  function automatic logic [63:0] ref_des(input logic [63:0] blk, input logic [63:0] key, input bit dec);
    logic [47:0] sk [16];
    logic [27:0] c, d;
    logic [55:0] cd;
    logic [63:0] x;
    logic [31:0] l, r, t;
    int sh;
    cd = pc1(key);
    c = cd[55:28];
    d = cd[27:0];
    for (int i = 0; i < 16; i++) begin
      sh = (i == 0 || i == 1 || i == 8 || i == 15) ? 1 : 2;
      c = (c << sh) | (c >> (28 - sh));
      d = (d << sh) | (d >> (28 - sh));
      sk[i] = pc2({c, d});
    end
    x = init_perm(blk);
    l = x[63:32];
    r = x[31:0];
    for (int i = 0; i < 16; i++) begin
      t = r;
      r = l ^ feistel(r, dec ? sk[15-i] : sk[i]);
      l = t;
    end
    return final_perm({r, l});
  endfunction

  function automatic logic [63:0] ref_cipher(input logic [63:0] blk);
    logic [63:0] k3e;
    k3e = m_two ? m_k1 : m_k3;
    if (!m_tri) return ref_des(blk, m_k1, m_dec);
    if (!m_dec) return ref_des(ref_des(ref_des(blk, m_k1, 0), m_k2, 1), k3e, 0);
    return ref_des(ref_des(ref_des(blk, k3e, 1), m_k2, 0), m_k1, 1);
  endfunction

  task automatic start_msg(input bit c, input bit dc, input bit tr, input bit tw,
                           input logic [63:0] a, input logic [63:0] b, input logic [63:0] e,
                           input logic [63:0] v);
    @(negedge clk);
    cbc = c; decrypt = dc; triple = tr; two_key = tw;
    key1 = a; key2 = b; key3 = e; iv = v;
    msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    // scramble live inputs: latched copies must be used
    key1 = ~a; key2 = ~b; key3 = ~e; iv = ~v; cbc = ~c; decrypt = ~dc;
    m_cbc = c; m_dec = dc; m_tri = tr; m_two = tw;
    m_k1 = a; m_k2 = b; m_k3 = e; m_chain = v;
  endtask

  // sends one block, checks latency/ready/hold, returns result and model expectation
  task automatic run_block(input logic [63:0] blk, input int stall, input string req,
                           output logic [63:0] got, output logic [63:0] exp);
    int cnt;
    int lat;
    bit busy_ok;
    logic [63:0] held;
    if (m_cbc && !m_dec) begin
      exp = ref_cipher(blk ^ m_chain);
      m_chain = exp;
    end else if (m_cbc) begin
      exp = ref_cipher(blk) ^ m_chain;
      m_chain = blk;
    end else begin
      exp = ref_cipher(blk);
    end
    lat = m_tri ? 48 : 16;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = blk;
    chk(in_ready === 1'b1, "R9 ready before block", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~blk;
    cnt = 0;
    busy_ok = 1'b1;
    while (out_valid !== 1'b1 && cnt < 200) begin
      if (in_ready !== 1'b0) busy_ok = 1'b0;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == lat, "R8 latency", 64'(cnt), 64'(lat));
    chk(busy_ok, "R9 ready low while busy", {63'd0, busy_ok}, 64'd1);
    held = out_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === held, "R9 output hold", out_data, held);
    end
    got = out_data;
    chk(got === exp, req, got, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 released after take",
        {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  localparam logic [63:0] KAT_K = 64'h133457799BBCDFF1;
  localparam logic [63:0] KAT_P = 64'h0123456789ABCDEF;
  localparam logic [63:0] KAT_C = 64'h85E813540F0AB405;
  localparam logic [63:0] PAR   = 64'h0101010101010101;

  initial begin
    logic [63:0] got, exp, a, b, c3, g1;
    logic [63:0] ct [3];
    logic [63:0] pt [3];
    pt[0] = 64'h4E6F772069732074; pt[1] = 64'h68652074696D6520; pt[2] = 64'h666F7220616C6C20;
    a  = 64'h0123456789ABCDEF;
    b  = 64'h23456789ABCDEF01;
    c3 = 64'h456789ABCDEF0123;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R10 reset state",
        {62'd0, in_ready, out_valid}, 64'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R10 after reset release",
        {62'd0, in_ready, out_valid}, 64'h2);

    // R1 known answer, model and design
    chk(ref_des(KAT_P, KAT_K, 0) === KAT_C, "R1 model known answer", ref_des(KAT_P, KAT_K, 0), KAT_C);
    start_msg(0, 0, 0, 0, KAT_K, 64'd0, 64'd0, 64'd0);
    run_block(KAT_P, 3, "R1 single ECB encrypt", got, exp);
    chk(got === KAT_C, "R1 known answer", got, KAT_C);

    // R7 parity bits ignored
    start_msg(0, 0, 0, 0, KAT_K ^ PAR, 64'd0, 64'd0, 64'd0);
    run_block(KAT_P, 0, "R7 parity flipped key", got, exp);
    chk(got === KAT_C, "R7 parity ignored", got, KAT_C);

    // R2 single decrypt
    start_msg(0, 1, 0, 0, KAT_K, 64'd0, 64'd0, 64'd0);
    run_block(KAT_C, 2, "R2 single ECB decrypt", got, exp);
    chk(got === KAT_P, "R2 decrypt inverts", got, KAT_P);

    // R3 equal keys collapse to single DES
    start_msg(0, 0, 1, 0, KAT_K, KAT_K, KAT_K, 64'd0);
    run_block(KAT_P, 1, "R3 triple equal keys", got, exp);
    chk(got === KAT_C, "R3 equal keys match single", got, KAT_C);

    // R3 three-key round trip
    start_msg(0, 0, 1, 0, a, b, c3, 64'd0);
    run_block(pt[0], 4, "R3 triple encrypt", got, exp);
    g1 = got;
    start_msg(0, 1, 1, 0, a ^ PAR, b, c3 ^ PAR, 64'd0);
    run_block(g1, 0, "R3 R7 triple decrypt", got, exp);
    chk(got === pt[0], "R3 triple round trip", got, pt[0]);

    // R4 two-key: key3 has no effect
    start_msg(0, 0, 1, 1, a, b, 64'hFFFF0000AAAA5555, 64'd0);
    run_block(pt[1], 0, "R4 two key encrypt", got, exp);
    g1 = got;
    start_msg(0, 0, 1, 1, a, b, 64'h1234123412341234, 64'd0);
    run_block(pt[1], 0, "R4 two key other key3", got, exp);
    chk(got === g1, "R4 key3 ignored", got, g1);
    chk(got === ref_des(ref_des(ref_des(pt[1], a, 0), b, 1), a, 0), "R4 K3 equals K1",
        got, ref_des(ref_des(ref_des(pt[1], a, 0), b, 1), a, 0));

    // R5 CBC encrypt, single then triple
    start_msg(1, 0, 0, 0, KAT_K, 64'd0, 64'd0, 64'h1234567890ABCDEF);
    for (int i = 0; i < 3; i++) run_block(pt[i], i, "R5 CBC single encrypt", got, exp);
    start_msg(1, 0, 1, 0, a, b, c3, 64'h0F1E2D3C4B5A6978);
    for (int i = 0; i < 3; i++) begin
      run_block(pt[i], 1, "R5 CBC triple encrypt", got, exp);
      ct[i] = got;
    end

    // R6 R11 CBC decrypt with restarted IV recovers plaintext
    start_msg(1, 1, 1, 0, a, b, c3, 64'h0F1E2D3C4B5A6978);
    for (int i = 0; i < 3; i++) begin
      run_block(ct[i], 2, "R6 CBC triple decrypt", got, exp);
      chk(got === pt[i], "R6 CBC round trip", got, pt[i]);
    end

    // R11 restart reproduces first ciphertext
    start_msg(1, 0, 1, 0, a, b, c3, 64'h0F1E2D3C4B5A6978);
    run_block(pt[0], 0, "R11 restart encrypt", got, exp);
    chk(got === ct[0], "R11 chain reloaded", got, ct[0]);

    // R6 single-DES CBC decrypt of two equal blocks differs by chaining
    start_msg(1, 1, 0, 0, KAT_K, 64'd0, 64'd0, 64'h00000000FFFFFFFF);
    run_block(KAT_C, 0, "R6 CBC single decrypt", got, exp);
    chk(got === (KAT_P ^ 64'h00000000FFFFFFFF), "R6 first block xor IV", got, KAT_P ^ 64'h00000000FFFFFFFF);
    run_block(KAT_C, 0, "R6 CBC single decrypt second", got, exp);
    chk(got === (KAT_P ^ KAT_C), "R6 second block xor prior ct", got, KAT_P ^ KAT_C);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule